// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block turns parallel PCM capture samples into a single serial data line and generates the matching bit clock and frame clock as the clock master. One mode code picks the frame layout: four two-channel formats (I2S, left-justified, right-justified and a frame-start-pulse format called DSP here) and two packed multichannel formats with 32-bit slots and 128 or 256 bit clocks per frame. A width code picks 16, 20 or 24 valid bits per sample.

Four 24-bit channel words arrive side by side on one bus: channel 0 is left 0, channel 1 is left 1, channel 2 is right 0, channel 3 is right 1. Each word is right-aligned, so only its low W bits are sent. The two-channel formats use channels 0 and 2. A single-cycle pulse on `bit_en_i` moves the block forward one bit period. On the first bit of every frame the block takes the mode, the width and, when `smp_rdy_i` is high, a new sample set. It acknowledges that capture with a one-cycle pulse.

Top module: `aud_ser_tx`

## Requirements
- R1: While reset is applied and until the first bit step, `sdata_o` is 0, `fclk_o` is 0, `bclk_o` is 1 and `smp_ack_o` is 0. The first step after reset emits bit 0 of a frame.
- R2: Each `bit_en_i` pulse, which is never high on two consecutive cycles, drives `bclk_o` low for exactly the next cycle. `sdata_o` and `fclk_o` take their new values at that same edge and change at no other time, so a receiver samples them on the rising bit-clock edge.
- R3: Mode codes are 000 I2S, 001 right-justified, 010 DSP, 011 left-justified, 100 packed 256 and 101 packed 128. Codes 110 and 111 behave as I2S.
- R4: Width code 00 gives 24 bits, 01 gives 20, 10 gives 16, and 11 is handled as 24. Each channel word sends its low W bits, MSB first, and ignores its upper bits.
- R5: I2S uses a 64-bit frame. `fclk_o` is 0 for bits 0 to 31 (left, channel 0) and 1 for bits 32 to 63 (right, channel 2). Each MSB sits one bit after the start of its half, at bits 1 and 33.
- R6: Left-justified uses a 64-bit frame. `fclk_o` is 1 during the left half and 0 during the right half. The MSBs sit at bits 0 and 32.
- R7: Right-justified has the same frame and `fclk_o` as left-justified. The LSB of each channel sits on the last bit of its half (bits 31 and 63), so the MSB starts at 32-W and at 64-W.
- R8: DSP uses a 64-bit frame. `fclk_o` is 1 only during bit 0. The left MSB is at bit 1 and the right word follows directly from bit 1+W. All later bits are 0.
- R9: Packed 128 has four 32-bit slots carrying channels 0, 1, 2, 3 in that order, each MSB at its slot start. `fclk_o` is 1 for bits 0 to 63.
- R10: Packed 256 has eight 32-bit slots. Channels 0 and 1 go in slots 0 and 1, and channels 2 and 3 go in slots 4 and 5. Slots 2, 3, 6 and 7 are 0. `fclk_o` is 1 for bits 0 to 127.
- R11: Every bit of a half or slot that lies outside the placed W-bit word is 0.
- R12: Changes to the mode or width codes during a frame have no effect until the next frame begins.
- R13: If `smp_rdy_i` is high at the first step of a frame, the sample bus is captured for that whole frame. `smp_ack_o` is then high for the one cycle after that step. If `smp_rdy_i` is low, the frame carries all-zero data and no acknowledge is given. Changes to the sample bus during a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en_i | input | 1 | One-cycle pulse per bit period |
| fmt_i | input | 3 | Frame layout code |
| width_i | input | 2 | Valid-bit width code |
| smp_i | input | 96 | Four 24-bit channel words, channel n at bits n*24 upward |
| smp_rdy_i | input | 1 | A new sample set is available |
| smp_ack_o | output | 1 | Sample set captured for the frame now starting |
| bclk_o | output | 1 | Bit clock, low for one cycle after each step |
| fclk_o | output | 1 | Frame clock |
| sdata_o | output | 1 | Serial data |

## Verification
Every serial output is registered at the clock edge that samples `bit_en_i` high. Bit k of a frame, its frame-clock level, the bit-clock low phase and the acknowledge pulse are therefore all due in the cycle after the k-th step. The bit clock returns high one cycle after that. The bench drives each step between edges, reads the outputs at the falling edge that follows, and reads them again one cycle later to confirm the rising bit clock and unchanged data. It checks each whole frame against a layout it builds independently by placing the words. For R12 and R13 it changes the codes and the sample bus in the middle of a frame, then checks both that frame and the one after it.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    localparam int SMP_W       = 24;
    localparam int NUM_CH      = 4;
    localparam int SLOT_W      = 32;
    localparam int SLOT_LG     = $clog2(SLOT_W);
    localparam int STEREO_BITS = 2 * SLOT_W;
    localparam int PK128_BITS  = 4 * SLOT_W;
    localparam int PK256_BITS  = 8 * SLOT_W;
    localparam int CNT_W       = $clog2(PK256_BITS);
    localparam int WID_W       = $clog2(SMP_W + 1);
    localparam int CH_W        = $clog2(NUM_CH);
    localparam int BUS_W       = NUM_CH * SMP_W;
    localparam int IDX_W       = $clog2(BUS_W);

    typedef enum logic [2:0] {
        FMT_I2S   = 3'd0,
        FMT_RJ    = 3'd1,
        FMT_DSP   = 3'd2,
        FMT_LJ    = 3'd3,
        FMT_PK256 = 3'd4,
        FMT_PK128 = 3'd5
    } fmt_e;

    typedef struct packed {
        fmt_e             fmt;
        logic [WID_W-1:0] width;
    } cfg_t;

    localparam cfg_t CFG_RST = '{fmt: FMT_I2S, width: WID_W'(SMP_W)};

    // Unused layout codes fall back to I2S; the invalid width code to full width.
    function automatic cfg_t decode_cfg(input logic [2:0] f, input logic [1:0] w);
        cfg_t c;
        case (f)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5: c.fmt = fmt_e'(f);
            default:                            c.fmt = FMT_I2S;
        endcase
        case (w)
            2'b01:   c.width = WID_W'(20);
            2'b10:   c.width = WID_W'(16);
            default: c.width = WID_W'(SMP_W);
        endcase
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] frame_last(input fmt_e f);
        case (f)
            FMT_PK256: return CNT_W'(PK256_BITS - 1);
            FMT_PK128: return CNT_W'(PK128_BITS - 1);
            default:   return CNT_W'(STEREO_BITS - 1);
        endcase
    endfunction

endpackage

// File: rtl/aud_tx_frame_ctl.sv
module aud_tx_frame_ctl
    import aud_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic [2:0]       fmt_code_i,
    input  logic [1:0]       width_code_i,
    output logic [CNT_W-1:0] cnt_o,
    output cfg_t             cfg_o,
    output logic             first_o
);

    logic [CNT_W-1:0] cnt_q;
    cfg_t             cfg_q;

    // On the first bit of a frame the fresh codes are used directly, so the
    // frame starts without a lost cycle; later bits use the latched copy.
    assign first_o = (cnt_q == '0);
    assign cfg_o   = first_o ? decode_cfg(fmt_code_i, width_code_i) : cfg_q;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cfg_q <= CFG_RST;
        end else if (step_i) begin
            if (first_o) cfg_q <= cfg_o;
            cnt_q <= (cnt_q == frame_last(cfg_o.fmt)) ? '0 : cnt_q + 1'b1;
        end
    end

    // R12: the frame configuration holds apart from the first-bit step
    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !(step_i && first_o) |=> $stable(cfg_q));

    // R3: the bit index never passes the end of the frame layout in use
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= frame_last(cfg_q.fmt));

endmodule

// File: rtl/aud_tx_bit_sel.sv
module aud_tx_bit_sel
    import aud_tx_pkg::*;
(
    input  cfg_t             cfg_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [BUS_W-1:0] smp_i,
    output logic             bit_o,
    output logic             fclk_o
);

    logic [SLOT_LG-1:0] pos;
    logic [SLOT_LG-1:0] off;
    logic [SLOT_LG:0]   t;
    logic [SLOT_LG:0]   u;
    logic               half;
    logic [1:0]         sub;
    logic               valid;
    logic [CH_W-1:0]    ch;
    logic [WID_W-1:0]   k;
    logic [WID_W-1:0]   bit_idx;
    logic [IDX_W-1:0]   sel;

    always_comb begin
        valid  = 1'b0;
        ch     = '0;
        k      = '0;
        fclk_o = 1'b0;
        half   = 1'b0;
        sub    = 2'd0;
        off    = '0;
        t      = cnt_i[SLOT_LG:0];
        u      = t - 1'b1;
        pos    = cnt_i[SLOT_LG-1:0];
        case (cfg_i.fmt)
            FMT_DSP: begin
                fclk_o = (cnt_i == '0);
                if (t != '0) begin
                    if (u < {1'b0, cfg_i.width}) begin
                        valid = 1'b1;
                        k     = u[WID_W-1:0];
                    end else if (u < {cfg_i.width, 1'b0}) begin
                        valid = 1'b1;
                        ch    = CH_W'(2);
                        k     = WID_W'(u - {1'b0, cfg_i.width});
                    end
                end
            end
            FMT_PK128, FMT_PK256: begin
                if (cfg_i.fmt == FMT_PK128) begin
                    half = cnt_i[SLOT_LG+1];
                    sub  = {1'b0, cnt_i[SLOT_LG]};
                end else begin
                    half = cnt_i[SLOT_LG+2];
                    sub  = cnt_i[SLOT_LG+1:SLOT_LG];
                end
                fclk_o = !half;
                if (!sub[1] && (pos < cfg_i.width)) begin
                    valid = 1'b1;
                    ch    = {half, sub[0]};
                    k     = pos;
                end
            end
            default: begin
                half = cnt_i[SLOT_LG];
                case (cfg_i.fmt)
                    FMT_I2S: off = SLOT_LG'(1);
                    // wraps to SLOT_W - width: LSB on the last bit of the half
                    FMT_RJ:  off = SLOT_LG'(SLOT_W) - SLOT_LG'(cfg_i.width);
                    default: off = '0;
                endcase
                fclk_o = (cfg_i.fmt == FMT_I2S) ? half : !half;
                if ((pos >= off) && ((pos - off) < cfg_i.width)) begin
                    valid = 1'b1;
                    ch    = {half, 1'b0};
                    k     = pos - off;
                end
            end
        endcase
        bit_idx = cfg_i.width - 1'b1 - k;
        sel     = IDX_W'(ch) * IDX_W'(SMP_W) + IDX_W'(bit_idx);
        bit_o   = valid & smp_i[sel];
    end

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en_i,
    input  logic [2:0]       fmt_i,
    input  logic [1:0]       width_i,
    input  logic [BUS_W-1:0] smp_i,
    input  logic             smp_rdy_i,
    output logic             smp_ack_o,
    output logic             bclk_o,
    output logic             fclk_o,
    output logic             sdata_o
);

    logic [CNT_W-1:0] cnt;
    cfg_t             cfg;
    logic             first;
    logic [BUS_W-1:0] smp_q;
    logic [BUS_W-1:0] smp_eff;
    logic             nxt_bit;
    logic             nxt_fclk;

    aud_tx_frame_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .step_i       (bit_en_i),
        .fmt_code_i   (fmt_i),
        .width_code_i (width_i),
        .cnt_o        (cnt),
        .cfg_o        (cfg),
        .first_o      (first)
    );

    // A missing sample set at frame start sends a silent frame.
    assign smp_eff = first ? (smp_rdy_i ? smp_i : '0) : smp_q;

    aud_tx_bit_sel u_sel (
        .cfg_i  (cfg),
        .cnt_i  (cnt),
        .smp_i  (smp_eff),
        .bit_o  (nxt_bit),
        .fclk_o (nxt_fclk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q     <= '0;
            smp_ack_o <= 1'b0;
            bclk_o    <= 1'b1;
            fclk_o    <= 1'b0;
            sdata_o   <= 1'b0;
        end else begin
            smp_ack_o <= bit_en_i && first && smp_rdy_i;
            if (bit_en_i) begin
                if (first) smp_q <= smp_eff;
                sdata_o <= nxt_bit;
                fclk_o  <= nxt_fclk;
                bclk_o  <= 1'b0;
            end else begin
                bclk_o  <= 1'b1;
            end
        end
    end

    // R2: serial outputs move only on a bit step (falling bit clock)
    p_data_on_step_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_en_i |=> ($stable(sdata_o) && $stable(fclk_o)));

    // R2: bit clock low phase lasts one cycle
    p_bclk_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        !bclk_o |=> bclk_o);

    // R2: steps are never back to back
    p_step_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        bit_en_i |=> !bit_en_i);

    // R13: acknowledge only accompanies the first bit of a frame
    p_ack_frame_start_r13: assert property (@(posedge clk) disable iff (rst)
        smp_ack_o |-> (cnt == CNT_W'(1)));

endmodule

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;
    // {rdy, fmt[2:0], width[1:0]}
    localparam logic [5:0] VEC [NVEC] = '{
        {1'b1, 3'd0, 2'd0}, {1'b1, 3'd0, 2'd2}, {1'b1, 3'd3, 2'd1},
        {1'b1, 3'd1, 2'd0}, {1'b1, 3'd1, 2'd2}, {1'b1, 3'd1, 2'd1},
        {1'b1, 3'd2, 2'd0}, {1'b1, 3'd2, 2'd2}, {1'b1, 3'd5, 2'd0},
        {1'b1, 3'd5, 2'd1}, {1'b1, 3'd4, 2'd2}, {1'b1, 3'd4, 2'd0},
        {1'b1, 3'd6, 2'd3}, {1'b0, 3'd7, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_en;
    logic [2:0]  fmt;
    logic [1:0]  wid;
    logic [95:0] smp;
    logic        rdy;
    logic        ack, bclk, fclk, sdata;

    int checks = 0;
    int errors = 0;

    logic s_d, s_f, s_b, s_ack, s_b2, s_d2, s_f2;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_ser_tx dut_i (
        .clk       (clk),
        .rst       (rst),
        .bit_en_i  (bit_en),
        .fmt_i     (fmt),
        .width_i   (wid),
        .smp_i     (smp),
        .smp_rdy_i (rdy),
        .smp_ack_o (ack),
        .bclk_o    (bclk),
        .fclk_o    (fclk),
        .sdata_o   (sdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [95:0] mk_smp(input int v);
        logic [95:0] s;
        for (int n = 0; n < 4; n++)
            s[n*24 +: 24] = 24'(32'h9A3C5F ^ (v * 32'h1F3B7 + n * 32'h52A91));
        return s;
    endfunction

    // Reference layout built by placing whole words (R3..R11, R13)
    task automatic build(input logic [2:0] fc, input logic [1:0] wc, input bit r,
                         input logic [95:0] s, output logic [255:0] ed,
                         output logic [255:0] ef, output int n);
        int w;
        int m;
        w  = (wc == 2'd1) ? 20 : (wc == 2'd2) ? 16 : 24;
        m  = (fc > 3'd5) ? 0 : int'(fc);
        ed = '0;
        ef = '0;
        n  = 64;
        case (m)
            0: begin
                for (int b = 32; b < 64; b++) ef[b] = 1'b1;
                for (int j = 0; j < w; j++) begin
                    ed[1 + j]  = s[0*24 + w-1-j];
                    ed[33 + j] = s[2*24 + w-1-j];
                end
            end
            3: begin
                for (int b = 0; b < 32; b++) ef[b] = 1'b1;
                for (int j = 0; j < w; j++) begin
                    ed[j]      = s[0*24 + w-1-j];
                    ed[32 + j] = s[2*24 + w-1-j];
                end
            end
            1: begin
                for (int b = 0; b < 32; b++) ef[b] = 1'b1;
                for (int j = 0; j < w; j++) begin
                    ed[32 - w + j] = s[0*24 + w-1-j];
                    ed[64 - w + j] = s[2*24 + w-1-j];
                end
            end
            2: begin
                ef[0] = 1'b1;
                for (int j = 0; j < w; j++) begin
                    ed[1 + j]     = s[0*24 + w-1-j];
                    ed[1 + w + j] = s[2*24 + w-1-j];
                end
            end
            5: begin
                n = 128;
                for (int b = 0; b < 64; b++) ef[b] = 1'b1;
                for (int c = 0; c < 4; c++)
                    for (int j = 0; j < w; j++) ed[32*c + j] = s[c*24 + w-1-j];
            end
            default: begin
                n = 256;
                for (int b = 0; b < 128; b++) ef[b] = 1'b1;
                for (int c = 0; c < 4; c++)
                    for (int j = 0; j < w; j++)
                        ed[(c < 2 ? 32*c : 128 + 32*(c-2)) + j] = s[c*24 + w-1-j];
            end
        endcase
        if (!r) ed = '0;
    endtask

    // One bit period: pulse, sample the registered outputs, sample again a cycle later
    task automatic step();
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
        s_d = sdata; s_f = fclk; s_b = bclk; s_ack = ack;
        @(negedge clk);
        s_b2 = bclk; s_d2 = sdata; s_f2 = fclk;
    endtask

    task automatic run_frame(input int n, input string tag, input logic [255:0] ed,
                             input logic [255:0] ef, input bit exp_ack,
                             input int chg_at, input logic [2:0] nf,
                             input logic [1:0] nw, input logic [95:0] ns);
        logic [255:0] gd, gf;
        int bad_d, bad_f, bad_a, bad_t;
        gd = '0; gf = '0;
        bad_d = -1; bad_f = -1; bad_a = 0; bad_t = 0;
        for (int i = 0; i < n; i++) begin
            step();
            gd[i] = s_d;
            gf[i] = s_f;
            if (s_ack !== ((i == 0) ? exp_ack : 1'b0)) bad_a++;
            if (s_b !== 1'b0 || s_b2 !== 1'b1 || s_d2 !== s_d || s_f2 !== s_f) bad_t++;
            if (i == chg_at) begin fmt = nf; wid = nw; smp = ns; end
        end
        for (int b = n - 1; b >= 0; b--) begin
            if (gd[b] !== ed[b]) bad_d = b;
            if (gf[b] !== ef[b]) bad_f = b;
        end
        chk(bad_d < 0, $sformatf("%s data bit %0d", tag, bad_d),
            (bad_d < 0) ? 32'd0 : 32'(gd[bad_d]), (bad_d < 0) ? 32'd0 : 32'(ed[bad_d]));
        chk(bad_f < 0, $sformatf("%s frame clock bit %0d", tag, bad_f),
            (bad_f < 0) ? 32'd0 : 32'(gf[bad_f]), (bad_f < 0) ? 32'd0 : 32'(ef[bad_f]));
        chk(bad_a == 0, {tag, " R13 ack pulse count of mismatches"}, 32'(bad_a), 32'd0);
        chk(bad_t == 0, {tag, " R2 bit clock / stable data mismatches"}, 32'(bad_t), 32'd0);
    endtask

    function automatic string tag_of(input logic [5:0] v);
        string t;
        case ((v[4:2] > 3'd5) ? 3'd0 : v[4:2])
            3'd0: t = "R5";
            3'd3: t = "R6";
            3'd1: t = "R7";
            3'd2: t = "R8";
            3'd5: t = "R9";
            default: t = "R10";
        endcase
        t = {t, " R11"};
        if (v[4:2] > 3'd5) t = {t, " R3"};
        if (v[1:0] == 2'd3 || v[1:0] == 2'd1) t = {t, " R4"};
        if (!v[5]) t = {t, " R13"};
        return t;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [255:0] ed, ef;
        int n;
        rst = 1'b1; bit_en = 1'b0; fmt = 3'd0; wid = 2'd0; smp = '0; rdy = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset values while reset is held
        chk(bclk === 1'b1 && sdata === 1'b0, "R1 bclk/sdata in reset", {30'd0, bclk, sdata}, 32'd2);
        @(negedge clk) rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(sdata === 1'b0, "R1 sdata idle", 32'(sdata), 32'd0);
        chk(fclk === 1'b0, "R1 fclk idle", 32'(fclk), 32'd0);
        chk(bclk === 1'b1, "R1 bclk idle", 32'(bclk), 32'd1);
        chk(ack === 1'b0, "R1 ack idle", 32'(ack), 32'd0);

        // Table-driven frames: R3..R11, R13
        for (int v = 0; v < NVEC; v++) begin
            fmt = VEC[v][4:2];
            wid = VEC[v][1:0];
            rdy = VEC[v][5];
            smp = mk_smp(v);
            build(fmt, wid, rdy, smp, ed, ef, n);
            run_frame(n, tag_of(VEC[v]), ed, ef, rdy, -1, fmt, wid, smp);
        end

        // R12 and R13: codes and samples change at bit 10 of a left-justified frame
        fmt = 3'd3; wid = 2'd0; rdy = 1'b1; smp = mk_smp(40);
        build(3'd3, 2'd0, 1'b1, mk_smp(40), ed, ef, n);
        run_frame(n, "R12 R13 mid-frame change ignored", ed, ef, 1'b1, 10, 3'd2, 2'd2, mk_smp(41));
        build(3'd2, 2'd2, 1'b1, mk_smp(41), ed, ef, n);
        run_frame(n, "R12 new codes at next frame R8", ed, ef, 1'b1, -1, fmt, wid, smp);

        finish_run();
    end

endmodule